// File: doc/BRIEF.md
# Pointer Masking Address Transform

This block sits between a core's address generation stage and its MMU. For every memory access it takes the virtual address, an access-class code, the current privilege and virtualization state, the modified-privilege controls, and one masking setting per privilege context. It returns the address that should go on to translation. For qualifying accesses, the top PMLEN bits of that address are replaced. For accesses that must not be touched, it returns the address unchanged. It also returns the value that the trap logic should record as the faulting address.

Masking is applied only to explicit data loads and stores. These include hypervisor virtual-machine loads and stores, and loads and stores that run under modified privilege. The following accesses pass straight through whatever the settings are:

- instruction fetch
- page-table-walk reads
- hypervisor execute-permission loads
- M-mode loads with both MPRV and MXR set

The setting used is the one belonging to the privilege context on whose behalf the access is made. When translation is active, the replaced bits copy bit 63−PMLEN. For a bare physical access they become zeros. A parameter chooses either a registered result or a purely combinational one.

Top module: `pm_addr_xform`

## Requirements
- R1: A load (class 0) or store (class 1) that does not run under modified privilege is masked with the setting of the current context. Contexts are M (priv 3), HS (priv 1, virt 0), HU (priv 0, virt 0), VS (priv 1, virt 1) and VU (priv 0, virt 1). The setting code 0 means off, 1 means PMLEN 7, 2 means PMLEN 16, and 3 is reserved and acts as off.
- R2: Instruction fetch (class 2) and the reserved class 7 leave the address unchanged for every setting.
- R3: Page-table-walk accesses (class 3) leave the address unchanged for every setting.
- R4: Hypervisor execute-permission loads (class 4) leave the address unchanged for every setting.
- R5: In M-mode with MPRV=1 and MXR=1, a load is left unchanged. A store under the same conditions is still masked as R6 describes.
- R6: In M-mode with MPRV=1, a load or store is masked with the setting selected by MPP. MPP 3 selects M, 1 selects HS, and 0 or 2 selects HU.
- R7: Hypervisor virtual-machine loads (class 5) and stores (class 6) use the VS setting when SPVP=1 and the VU setting when SPVP=0.
- R8: When masking applies and xlate_on=1, each of the top PMLEN bits becomes a copy of bit 63−PMLEN. When xlate_on=0, those bits become zeros.
- R9: trap_addr always equals the address sent on to the MMU, so a faulting masked access reports the masked value.
- R10: With REG_OUT=1, results appear at the first rising edge after the inputs are sampled. While rst_n is low, both outputs read zero.
- R11: Bits 47..0 of the output always equal the same bits of the input address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_addr | input | 64 | Virtual address from address generation |
| acc_class | input | 3 | Access-class code (see R1 to R7) |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt_on | input | 1 | Hart runs in virtualized mode |
| mprv | input | 1 | Modified-privilege enable |
| mxr | input | 1 | Make-executable-readable flag |
| mpp | input | 2 | Previous privilege used under MPRV |
| spvp | input | 1 | Privilege for hypervisor VM loads/stores |
| xlate_on | input | 1 | Translation is active for this access |
| cfg_m | input | 2 | Masking setting, M context |
| cfg_hs | input | 2 | Masking setting, HS context |
| cfg_hu | input | 2 | Masking setting, HU context |
| cfg_vs | input | 2 | Masking setting, VS context |
| cfg_vu | input | 2 | Masking setting, VU context |
| mmu_addr | output | 64 | Address forwarded to the MMU |
| trap_addr | output | 64 | Value for the trap-value register |

## Verification
With the default REG_OUT=1, both results are due one rising edge after the inputs are applied. The bench drives a new access on a falling edge and compares both outputs on the next falling edge. By then exactly one rising edge has registered that access, and the next access has not yet been applied. The bound checker uses the same alignment: it keeps a one-cycle copy of the inputs and compares each output with the inputs of the previous cycle. During reset, the outputs are compared against zero on the falling edges while rst_n is held low.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        ACC_LOAD  = 3'd0,
        ACC_STORE = 3'd1,
        ACC_FETCH = 3'd2,
        ACC_WALK  = 3'd3,
        ACC_HLVX  = 3'd4,
        ACC_VLOAD = 3'd5,
        ACC_VSTOR = 3'd6,
        ACC_RSVD  = 3'd7
    } acc_e;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_R = 2'd2,
        PRV_M = 2'd3
    } prv_e;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_LENA = 2'd1,
        PM_LENB = 2'd2,
        PM_RSVD = 2'd3
    } pmcfg_e;

    typedef enum logic [2:0] {
        CTX_M  = 3'd0,
        CTX_HS = 3'd1,
        CTX_HU = 3'd2,
        CTX_VS = 3'd3,
        CTX_VU = 3'd4
    } ctx_e;

endpackage

// File: rtl/pm_ctx_sel.sv
module pm_ctx_sel
    import pm_pkg::*;
(
    input  logic [2:0] acc_class,
    input  logic [1:0] cur_priv,
    input  logic       virt_on,
    input  logic       mprv,
    input  logic       mxr,
    input  logic [1:0] mpp,
    input  logic       spvp,
    output logic       do_mask,
    output ctx_e       ctx
);

    acc_e acc;
    logic m_mode;
    ctx_e cur_ctx;
    ctx_e mpp_ctx;

    assign acc    = acc_e'(acc_class);
    assign m_mode = (cur_priv == PRV_M);

    // Context of the current privilege and virtualization state
    always_comb begin
        unique case (prv_e'(cur_priv))
            PRV_M:   cur_ctx = CTX_M;
            PRV_S:   cur_ctx = virt_on ? CTX_VS : CTX_HS;
            default: cur_ctx = virt_on ? CTX_VU : CTX_HU;
        endcase
    end

    // Context named by the previous-privilege field
    always_comb begin
        unique case (prv_e'(mpp))
            PRV_M:   mpp_ctx = CTX_M;
            PRV_S:   mpp_ctx = CTX_HS;
            default: mpp_ctx = CTX_HU;
        endcase
    end

    always_comb begin
        do_mask = 1'b0;
        ctx     = cur_ctx;
        unique case (acc)
            ACC_LOAD, ACC_STORE: begin
                if (m_mode && mprv) begin
                    ctx     = mpp_ctx;
                    do_mask = !((acc == ACC_LOAD) && mxr);
                end else begin
                    do_mask = 1'b1;
                end
            end
            ACC_VLOAD, ACC_VSTOR: begin
                ctx     = spvp ? CTX_VS : CTX_VU;
                do_mask = 1'b1;
            end
            default: begin
                do_mask = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pm_xform.sv
module pm_xform
    import pm_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_A = 7,
    parameter int LEN_B = 16
) (
    input  logic [XLEN-1:0] addr_i,
    input  logic            do_mask,
    input  logic [1:0]      cfg,
    input  logic            xlate_on,
    output logic [XLEN-1:0] addr_o
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]         sh;
    logic [XLEN-1:0]        up;
    logic signed [XLEN-1:0] up_s;

    always_comb begin
        unique case (pmcfg_e'(cfg))
            PM_LENA: sh = SHW'(LEN_A);
            PM_LENB: sh = SHW'(LEN_B);
            default: sh = '0;
        endcase
        if (!do_mask) sh = '0;
    end

    assign up   = addr_i << sh;
    assign up_s = $signed(up);

    always_comb begin
        if (xlate_on) addr_o = XLEN'(up_s >>> sh);
        else          addr_o = up >> sh;
    end

endmodule

// File: rtl/pm_addr_xform.sv
module pm_addr_xform
    import pm_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int LEN_A   = 7,
    parameter int LEN_B   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] in_addr,
    input  logic [2:0]      acc_class,
    input  logic [1:0]      cur_priv,
    input  logic            virt_on,
    input  logic            mprv,
    input  logic            mxr,
    input  logic [1:0]      mpp,
    input  logic            spvp,
    input  logic            xlate_on,
    input  logic [1:0]      cfg_m,
    input  logic [1:0]      cfg_hs,
    input  logic [1:0]      cfg_hu,
    input  logic [1:0]      cfg_vs,
    input  logic [1:0]      cfg_vu,
    output logic [XLEN-1:0] mmu_addr,
    output logic [XLEN-1:0] trap_addr
);

    logic            do_mask;
    ctx_e            ctx;
    logic [1:0]      sel_cfg;
    logic [XLEN-1:0] xf_addr;

    pm_ctx_sel u_ctx (
        .acc_class (acc_class),
        .cur_priv  (cur_priv),
        .virt_on   (virt_on),
        .mprv      (mprv),
        .mxr       (mxr),
        .mpp       (mpp),
        .spvp      (spvp),
        .do_mask   (do_mask),
        .ctx       (ctx)
    );

    always_comb begin
        unique case (ctx)
            CTX_M:   sel_cfg = cfg_m;
            CTX_HS:  sel_cfg = cfg_hs;
            CTX_VS:  sel_cfg = cfg_vs;
            CTX_VU:  sel_cfg = cfg_vu;
            default: sel_cfg = cfg_hu;
        endcase
    end

    pm_xform #(.XLEN(XLEN), .LEN_A(LEN_A), .LEN_B(LEN_B)) u_xf (
        .addr_i   (in_addr),
        .do_mask  (do_mask),
        .cfg      (sel_cfg),
        .xlate_on (xlate_on),
        .addr_o   (xf_addr)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [XLEN-1:0] mmu_q;
            logic [XLEN-1:0] tval_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mmu_q  <= '0;
                    tval_q <= '0;
                end else begin
                    mmu_q  <= xf_addr;
                    tval_q <= xf_addr;
                end
            end
            assign mmu_addr  = mmu_q;
            assign trap_addr = tval_q;
        end else begin : g_comb
            assign mmu_addr  = xf_addr;
            assign trap_addr = xf_addr;
        end
    endgenerate

endmodule

// File: rtl/pm_addr_xform_chk.sv
module pm_addr_xform_chk #(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] in_addr,
    input logic [2:0]      acc_class,
    input logic [1:0]      cur_priv,
    input logic            mprv,
    input logic            mxr,
    input logic            xlate_on,
    input logic [XLEN-1:0] mmu_addr,
    input logic [XLEN-1:0] trap_addr
);

    logic [XLEN-1:0] q_addr;
    logic [2:0]      q_acc;
    logic [1:0]      q_priv;
    logic            q_mprv;
    logic            q_mxr;
    logic            q_xl;
    logic            q_v;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_addr <= '0;
                    q_acc  <= '0;
                    q_priv <= '0;
                    q_mprv <= 1'b0;
                    q_mxr  <= 1'b0;
                    q_xl   <= 1'b0;
                    q_v    <= 1'b0;
                end else begin
                    q_addr <= in_addr;
                    q_acc  <= acc_class;
                    q_priv <= cur_priv;
                    q_mprv <= mprv;
                    q_mxr  <= mxr;
                    q_xl   <= xlate_on;
                    q_v    <= 1'b1;
                end
            end
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> (mmu_addr == '0) && (trap_addr == '0)); // R10
        end else begin : g_now
            assign q_addr = in_addr;
            assign q_acc  = acc_class;
            assign q_priv = cur_priv;
            assign q_mprv = mprv;
            assign q_mxr  = mxr;
            assign q_xl   = xlate_on;
            assign q_v    = rst_n;
        end
    endgenerate

    AST_FETCH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && (q_acc == 3'd2 || q_acc == 3'd7)) |-> mmu_addr == q_addr); // R2
    AST_WALK_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && q_acc == 3'd3) |-> mmu_addr == q_addr); // R3
    AST_HLVX_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && q_acc == 3'd4) |-> mmu_addr == q_addr); // R4
    AST_MXR_LOAD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && q_acc == 3'd0 && q_priv == 2'd3 && q_mprv && q_mxr)
        |-> mmu_addr == q_addr); // R5
    AST_BARE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && !q_xl && mmu_addr != q_addr)
        |-> mmu_addr[XLEN-1 -: 7] == 7'd0); // R8
    AST_TVAL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        q_v |-> trap_addr == mmu_addr); // R9
    AST_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        q_v |-> mmu_addr[XLEN-17:0] == q_addr[XLEN-17:0]); // R11

endmodule

bind pm_addr_xform pm_addr_xform_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_addr   (in_addr),
    .acc_class (acc_class),
    .cur_priv  (cur_priv),
    .mprv      (mprv),
    .mxr       (mxr),
    .xlate_on  (xlate_on),
    .mmu_addr  (mmu_addr),
    .trap_addr (trap_addr)
);

// File: tb/pm_addr_xform_tb.sv
`timescale 1ns/1ps
module pm_addr_xform_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_addr = '0;
    logic [2:0]  acc_class = '0;
    logic [1:0]  cur_priv = '0;
    logic        virt_on = 1'b0, mprv = 1'b0, mxr = 1'b0, spvp = 1'b0, xlate_on = 1'b0;
    logic [1:0]  mpp = '0;
    logic [1:0]  cfg_m = '0, cfg_hs = '0, cfg_hu = '0, cfg_vs = '0, cfg_vu = '0;
    logic [63:0] mmu_addr, trap_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pm_addr_xform u_dut (
        .clk(clk), .rst_n(rst_n), .in_addr(in_addr), .acc_class(acc_class),
        .cur_priv(cur_priv), .virt_on(virt_on), .mprv(mprv), .mxr(mxr),
        .mpp(mpp), .spvp(spvp), .xlate_on(xlate_on), .cfg_m(cfg_m),
        .cfg_hs(cfg_hs), .cfg_hu(cfg_hu), .cfg_vs(cfg_vs), .cfg_vu(cfg_vu),
        .mmu_addr(mmu_addr), .trap_addr(trap_addr)
    );

    function automatic int len_of(input logic [1:0] c);
        if (c == 2'd1) return 7;
        if (c == 2'd2) return 16;
        return 0;
    endfunction

    function automatic logic [1:0] cfg_for_priv(input logic [1:0] p, input logic v);
        if (p == 2'd3) return cfg_m;
        if (p == 2'd1) return v ? cfg_vs : cfg_hs;
        return v ? cfg_vu : cfg_hu;
    endfunction

    // Returns -1 when the access bypasses masking, else the PMLEN in force
    function automatic int exp_len();
        if (acc_class == 3'd5 || acc_class == 3'd6)
            return len_of(spvp ? cfg_vs : cfg_vu);
        if (acc_class == 3'd0 || acc_class == 3'd1) begin
            if (cur_priv == 2'd3 && mprv) begin
                if (acc_class == 3'd0 && mxr) return -1;
                return len_of(cfg_for_priv(mpp == 2'd2 ? 2'd0 : mpp, 1'b0));
            end
            return len_of(cfg_for_priv(cur_priv, virt_on));
        end
        return -1;
    endfunction

    function automatic logic [63:0] exp_addr();
        logic [63:0] r;
        int n;
        r = in_addr;
        n = exp_len();
        if (n > 0)
            for (int i = 64 - n; i < 64; i++) r[i] = xlate_on ? in_addr[63 - n] : 1'b0;
        return r;
    endfunction

    function automatic string tag_of();
        case (acc_class)
            3'd2, 3'd7: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5, 3'd6: return "R7";
            default: begin
                if (cur_priv == 2'd3 && mprv) return (acc_class == 3'd0 && mxr) ? "R5" : "R6";
                return "R1";
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive on a falling edge, result registered at the rising edge, compare on the next falling edge
    task automatic apply_and_check();
        logic [63:0] e;
        string t;
        e = exp_addr();
        t = tag_of();
        @(negedge clk);
        check(t, mmu_addr, e);
        if (exp_len() > 0) check(xlate_on ? "R8 sign" : "R8 zero", mmu_addr, e);
        check("R9", trap_addr, e);
        check("R11", {48'd0, mmu_addr[47:0]}, {48'd0, in_addr[47:0]});
    endtask

    task automatic rnd_ctx();
        logic [1:0] p;
        p = 2'($urandom_range(0, 2));
        cur_priv = (p == 2'd2) ? 2'd3 : p;
        virt_on  = (cur_priv != 2'd3) ? 1'($urandom) : 1'b0;
        mprv = 1'($urandom); mxr = 1'($urandom); spvp = 1'($urandom);
        mpp = 2'($urandom); xlate_on = 1'($urandom);
        cfg_m = 2'($urandom); cfg_hs = 2'($urandom); cfg_hu = 2'($urandom);
        cfg_vs = 2'($urandom); cfg_vu = 2'($urandom);
        in_addr = {$urandom, $urandom};
        acc_class = 3'($urandom);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        in_addr = 64'hFFFF_FFFF_FFFF_FFFF;
        acc_class = 3'd0;
        cfg_hu = 2'd2;
        repeat (3) @(negedge clk);
        check("R10 reset mmu", mmu_addr, 64'd0);
        check("R10 reset tval", trap_addr, 64'd0);
        rst_n = 1'b1;

        // Directed sweep: every class, every privilege, every PMLEN, both fill modes
        for (int a = 0; a < 8; a++)
            for (int pi = 0; pi < 3; pi++)
                for (int c = 0; c < 3; c++)
                    for (int x = 0; x < 2; x++) begin
                        acc_class = 3'(a);
                        cur_priv = (pi == 2) ? 2'd3 : 2'(pi);
                        virt_on = 1'b0; mprv = 1'b0; mxr = 1'b0; spvp = 1'(pi);
                        mpp = 2'd0; xlate_on = 1'(x);
                        cfg_m = 2'(c); cfg_hs = 2'(c); cfg_hu = 2'(c);
                        cfg_vs = 2'(c); cfg_vu = 2'(c);
                        in_addr = x ? 64'hA5C3_0F00_8000_1234 : 64'h5A3C_F0FF_7FFF_EDCB;
                        apply_and_check();
                    end

        // R5 / R6: M-mode modified privilege, distinct settings per context
        cur_priv = 2'd3; virt_on = 1'b0; mprv = 1'b1; xlate_on = 1'b1;
        cfg_m = 2'd0; cfg_hs = 2'd1; cfg_hu = 2'd2; cfg_vs = 2'd0; cfg_vu = 2'd0;
        in_addr = 64'h1234_8000_0000_0040;
        mxr = 1'b1; acc_class = 3'd0; mpp = 2'd1; apply_and_check();   // R5 load bypass
        mxr = 1'b1; acc_class = 3'd1; mpp = 2'd1; apply_and_check();   // R5 store masked, HS len 7
        mxr = 1'b0; acc_class = 3'd0; mpp = 2'd0; apply_and_check();   // R6 HU len 16
        mxr = 1'b0; acc_class = 3'd1; mpp = 2'd2; apply_and_check();   // R6 MPP 2 -> HU
        mxr = 1'b0; acc_class = 3'd0; mpp = 2'd3; apply_and_check();   // R6 M off

        // R7: hypervisor VM loads pick VS/VU by SPVP; reserved setting 3 acts as off (R1)
        mprv = 1'b0; cur_priv = 2'd1; cfg_vs = 2'd2; cfg_vu = 2'd1;
        acc_class = 3'd5; spvp = 1'b1; apply_and_check();
        acc_class = 3'd6; spvp = 1'b0; apply_and_check();
        acc_class = 3'd0; virt_on = 1'b1; cfg_vs = 2'd3; apply_and_check();
        // R1: virtualized user uses VU setting
        cur_priv = 2'd0; apply_and_check();

        for (int k = 0; k < 3000; k++) begin
            rnd_ctx();
            apply_and_check();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule